// File: doc/BRIEF.md
# JTAG Debug Port Scan Target

This block is the target-side data-register logic of a JTAG debug port. A separate IEEE 1149.1 TAP controller supplies one-cycle state strobes: capture, shift and update, for both the instruction path and the data path. The block uses these strobes to run its own 4-bit instruction register and a set of data registers. The data registers are a fixed identification word, a one-bit bypass stage, and a 35-bit access register. The access register carries a 3-bit request/response field and a 32-bit data word.

Debug-port accesses act on three local registers: control/status, bank select and read buffer. Access-port accesses go out on a simple internal register bus that holds its request until the responder signals ready. Reads are posted, so the data captured by any access scan is the result of the operation before it. A request that arrives while the bus is still busy gets a WAIT answer and is dropped. When overrun detection is on, such a request also sets a sticky overrun flag. A special abort scan cancels a hung bus transaction.

Top module: `jdp_scan_target`

## Requirements
- R1: After reset, and after every tap_reset pulse, the active instruction is IDCODE (4'hE). A data scan under IDCODE shifts out the 32-bit IDCODE_VALUE parameter, LSB first, and its bit 0 is 1.
- R2: An instruction capture loads 4'b0001. Codes 4'h8 (abort), 4'hA (debug-port access), 4'hB (access-port access) and 4'hE (identification) select their registers. Every other code selects a 1-bit bypass stage that captures 0.
- R3: An access scan is 35 bits, LSB first. Bit 0 is read-not-write, bits 2:1 are register address A[3:2], and bits 34:3 are the data word. Debug-port address 1 is control/status, 2 is bank select and 3 is the read buffer.
- R4: The 3-bit field captured by an access scan is 3'b001 (WAIT) when a bus request is outstanding and 3'b010 (OK/FAULT) otherwise.
- R5: Read data is posted. The data captured by an access scan is the result of the preceding read. Reading the read buffer (address 3) returns that value and does not change it.
- R6: A debug-port or access-port request whose scan answered WAIT is discarded. If control/status bit 0 (overrun detect) is 1, the discard also sets sticky overrun (bit 1); otherwise bit 1 is unchanged.
- R7: Writing 1 to control/status bit 1 or bit 5 clears that sticky bit. Writing 0 leaves it unchanged.
- R8: Control/status bits 28 (debug power request) and 30 (system power request) are writable. Bits 29 and 31 read back as the matching acknowledges.
- R9: Select bits 7:4 hold the access-port bank. An access-port request drives bus_addr = {bank, A[3:2], 2'b00}. The select register reads back only bits 7:4.
- R10: A bus completion with bus_err set raises sticky error (bit 5). While bit 1 or bit 5 is set, access-port requests are dropped without a bus request.
- R11: An abort scan whose data word equals 1 cancels the outstanding bus request and pulses bus_abort for one cycle. Any other data word has no effect.
- R12: bus_req, bus_wr, bus_addr and bus_wdata stay stable from the request until the cycle in which bus_ready is high, and bus_req drops the cycle after.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock; the register bus shares it |
| rst_n | input | 1 | Asynchronous active-low reset |
| tap_reset | input | 1 | TAP in Test-Logic-Reset |
| capture_ir | input | 1 | TAP in Capture-IR |
| shift_ir | input | 1 | TAP in Shift-IR |
| update_ir | input | 1 | TAP in Update-IR |
| capture_dr | input | 1 | TAP in Capture-DR |
| shift_dr | input | 1 | TAP in Shift-DR |
| update_dr | input | 1 | TAP in Update-DR |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out |
| bus_req | output | 1 | Access-port request outstanding |
| bus_wr | output | 1 | Request is a write |
| bus_addr | output | 8 | Access-port register byte address |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, valid with bus_ready |
| bus_ready | input | 1 | Responder completes the request |
| bus_err | input | 1 | Completion carried an error |
| bus_abort | output | 1 | One-cycle cancel pulse |

## Verification
The assertions assume that the TAP strobes are mutually exclusive and follow the legal order: each update_dr comes after a capture_dr. They also assume that bus_ready is only high while bus_req is high. The bench drives the strobes only through complete capture, shift and update tasks. Its bus responder raises ready for exactly one cycle, counted from the request, so the handshake stays inside these assumptions. Bus latency is kept short for back-to-back scans, and long latencies are used where the WAIT and abort paths are the target.

// File: rtl/jdp_pkg.sv
package jdp_pkg;
  localparam int IR_W   = 4;
  localparam int DW     = 32;
  localparam int ACK_W  = 3;
  localparam int A_W    = 2;
  localparam int BANK_W = 4;
  localparam int ACC_W  = DW + A_W + 1;
  localparam int BUS_AW = BANK_W + A_W + 2;

  localparam logic [IR_W-1:0] IR_ABORT   = 4'h8;
  localparam logic [IR_W-1:0] IR_DPACC   = 4'hA;
  localparam logic [IR_W-1:0] IR_APACC   = 4'hB;
  localparam logic [IR_W-1:0] IR_IDCODE  = 4'hE;
  localparam logic [IR_W-1:0] IR_CAPTURE = 4'b0001;

  localparam logic [ACK_W-1:0] ACK_OK   = 3'b010;
  localparam logic [ACK_W-1:0] ACK_WAIT = 3'b001;

  localparam logic [A_W-1:0] DPR_CTRL   = 2'd1;
  localparam logic [A_W-1:0] DPR_SELECT = 2'd2;
  localparam logic [A_W-1:0] DPR_RDBUF  = 2'd3;

  localparam int CS_ORUN_EN   = 0;
  localparam int CS_ORUN      = 1;
  localparam int CS_ERR       = 5;
  localparam int CS_DPWR_REQ  = 28;
  localparam int CS_DPWR_ACK  = 29;
  localparam int CS_SPWR_REQ  = 30;
  localparam int CS_SPWR_ACK  = 31;
  localparam int SEL_BANK_LSB = 4;

  typedef struct packed {
    logic [DW-1:0]  data;
    logic [A_W-1:0] addr;
    logic           rnw;
  } acc_word_t;

  typedef enum logic [1:0] {DR_BYPASS, DR_IDCODE, DR_ACCESS} dr_kind_e;

  function automatic dr_kind_e dr_kind(input logic [IR_W-1:0] code);
    case (code)
      IR_IDCODE:                     return DR_IDCODE;
      IR_ABORT, IR_DPACC, IR_APACC:  return DR_ACCESS;
      default:                       return DR_BYPASS;
    endcase
  endfunction
endpackage

// File: rtl/jdp_ir_reg.sv
module jdp_ir_reg
  import jdp_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tap_reset,
  input  logic            capture_ir,
  input  logic            shift_ir,
  input  logic            update_ir,
  input  logic            tdi,
  output logic [IR_W-1:0] ir,
  output logic            ir_tdo
);
  logic [IR_W-1:0] sh_q, sh_d, ir_q, ir_d;
  logic            sh_en, ir_en;

  always_comb begin
    sh_en = capture_ir | shift_ir;
    sh_d  = capture_ir ? IR_CAPTURE : {tdi, sh_q[IR_W-1:1]};
    ir_en = tap_reset | update_ir;
    ir_d  = tap_reset ? IR_IDCODE : sh_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= IR_CAPTURE;
      ir_q <= IR_IDCODE;
    end else begin
      if (sh_en) sh_q <= sh_d;
      if (ir_en) ir_q <= ir_d;
    end
  end

  assign ir     = ir_q;
  assign ir_tdo = sh_q[0];
endmodule

// File: rtl/jdp_dr_shift.sv
module jdp_dr_shift
  import jdp_pkg::*;
#(
  parameter logic [DW-1:0] IDCODE_VALUE = 32'h4BA0_1C35
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IR_W-1:0]  ir,
  input  logic             capture_dr,
  input  logic             shift_dr,
  input  logic             tdi,
  input  logic [ACK_W-1:0] cap_ack,
  input  logic [DW-1:0]    cap_data,
  output logic [ACC_W-1:0] dr,
  output logic             dr_tdo
);
  logic [ACC_W-1:0] dr_q, dr_d;
  logic             dr_en;
  dr_kind_e         kind;

  always_comb begin
    kind  = dr_kind(ir);
    dr_en = capture_dr | shift_dr;
    dr_d  = dr_q;
    if (capture_dr) begin
      case (kind)
        DR_IDCODE: dr_d = ACC_W'(IDCODE_VALUE);
        DR_ACCESS: dr_d = {cap_data, cap_ack};
        default:   dr_d = '0;
      endcase
    end else begin
      case (kind)
        DR_IDCODE: dr_d = {{(ACC_W-DW){1'b0}}, tdi, dr_q[DW-1:1]};
        DR_ACCESS: dr_d = {tdi, dr_q[ACC_W-1:1]};
        default:   dr_d = {{(ACC_W-1){1'b0}}, tdi};
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     dr_q <= '0;
    else if (dr_en) dr_q <= dr_d;
  end

  assign dr     = dr_q;
  assign dr_tdo = dr_q[0];
endmodule

// File: rtl/jdp_core.sv
module jdp_core
  import jdp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IR_W-1:0]   ir,
  input  logic              capture_dr,
  input  logic              update_dr,
  input  logic [ACC_W-1:0]  dr,
  output logic [ACK_W-1:0]  cap_ack,
  output logic [DW-1:0]     cap_data,
  output logic              bus_req,
  output logic              bus_wr,
  output logic [BUS_AW-1:0] bus_addr,
  output logic [DW-1:0]     bus_wdata,
  input  logic [DW-1:0]     bus_rdata,
  input  logic              bus_ready,
  input  logic              bus_err,
  output logic              bus_abort
);
  acc_word_t         req;
  logic              is_acc, ld_req;
  logic              pend_q, pend_d, wr_q, wr_d, waitc_q, waitc_d;
  logic [BUS_AW-1:0] addr_q, addr_d;
  logic [DW-1:0]     wdata_q, wdata_d, posted_q, posted_d, ctrl_rd, sel_rd, dp_rd;
  logic              orun_en_q, orun_en_d, orun_q, orun_d, err_q, err_d;
  logic              dpwr_q, dpwr_d, spwr_q, spwr_d, abort_q, abort_d;
  logic [BANK_W-1:0] bank_q, bank_d;

  always_comb begin
    ctrl_rd              = '0;
    ctrl_rd[CS_ORUN_EN]  = orun_en_q;
    ctrl_rd[CS_ORUN]     = orun_q;
    ctrl_rd[CS_ERR]      = err_q;
    ctrl_rd[CS_DPWR_REQ] = dpwr_q;
    ctrl_rd[CS_DPWR_ACK] = dpwr_q;
    ctrl_rd[CS_SPWR_REQ] = spwr_q;
    ctrl_rd[CS_SPWR_ACK] = spwr_q;
    sel_rd = '0;
    sel_rd[SEL_BANK_LSB +: BANK_W] = bank_q;
  end

  always_comb begin
    req       = acc_word_t'(dr);
    is_acc    = (ir == IR_DPACC) || (ir == IR_APACC);
    case (req.addr)
      DPR_CTRL:   dp_rd = ctrl_rd;
      DPR_SELECT: dp_rd = sel_rd;
      default:    dp_rd = '0;
    endcase
    pend_d    = pend_q;
    wr_d      = wr_q;
    addr_d    = addr_q;
    wdata_d   = wdata_q;
    ld_req    = 1'b0;
    posted_d  = posted_q;
    waitc_d   = waitc_q;
    orun_en_d = orun_en_q;
    orun_d    = orun_q;
    err_d     = err_q;
    dpwr_d    = dpwr_q;
    spwr_d    = spwr_q;
    bank_d    = bank_q;
    abort_d   = 1'b0;
    // bus completion
    if (pend_q && bus_ready) begin
      pend_d = 1'b0;
      if (!wr_q)   posted_d = bus_rdata;
      if (bus_err) err_d    = 1'b1;
    end
    // response decided when the scan captures
    if (capture_dr && is_acc) waitc_d = pend_q;
    // request issued on update
    if (update_dr) begin
      if (is_acc && waitc_q) begin
        if (orun_en_q) orun_d = 1'b1;
      end else if (ir == IR_DPACC) begin
        if (req.rnw) begin
          if (req.addr != DPR_RDBUF) posted_d = dp_rd;
        end else begin
          case (req.addr)
            DPR_CTRL: begin
              orun_en_d = req.data[CS_ORUN_EN];
              if (req.data[CS_ORUN]) orun_d = 1'b0;
              if (req.data[CS_ERR])  err_d  = 1'b0;
              dpwr_d = req.data[CS_DPWR_REQ];
              spwr_d = req.data[CS_SPWR_REQ];
            end
            DPR_SELECT: bank_d = req.data[SEL_BANK_LSB +: BANK_W];
            default: ;
          endcase
        end
      end else if (ir == IR_APACC) begin
        if (!(orun_q || err_q)) begin
          pend_d  = 1'b1;
          ld_req  = 1'b1;
          wr_d    = !req.rnw;
          addr_d  = {bank_q, req.addr, 2'b00};
          wdata_d = req.data;
        end
      end else if (ir == IR_ABORT) begin
        if (req.data == DW'(1)) begin
          pend_d  = 1'b0;
          abort_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q    <= 1'b0;
      wr_q      <= 1'b0;
      addr_q    <= '0;
      wdata_q   <= '0;
      posted_q  <= '0;
      waitc_q   <= 1'b0;
      orun_en_q <= 1'b0;
      orun_q    <= 1'b0;
      err_q     <= 1'b0;
      dpwr_q    <= 1'b0;
      spwr_q    <= 1'b0;
      bank_q    <= '0;
      abort_q   <= 1'b0;
    end else begin
      if (ld_req) begin
        wr_q    <= wr_d;
        addr_q  <= addr_d;
        wdata_q <= wdata_d;
      end
      pend_q    <= pend_d;
      posted_q  <= posted_d;
      waitc_q   <= waitc_d;
      orun_en_q <= orun_en_d;
      orun_q    <= orun_d;
      err_q     <= err_d;
      dpwr_q    <= dpwr_d;
      spwr_q    <= spwr_d;
      bank_q    <= bank_d;
      abort_q   <= abort_d;
    end
  end

  assign cap_ack   = pend_q ? ACK_WAIT : ACK_OK;
  assign cap_data  = posted_q;
  assign bus_req   = pend_q;
  assign bus_wr    = wr_q;
  assign bus_addr  = addr_q;
  assign bus_wdata = wdata_q;
  assign bus_abort = abort_q;
endmodule

// File: rtl/jdp_scan_target.sv
module jdp_scan_target
  import jdp_pkg::*;
#(
  parameter logic [DW-1:0] IDCODE_VALUE = 32'h4BA0_1C35
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tap_reset,
  input  logic              capture_ir,
  input  logic              shift_ir,
  input  logic              update_ir,
  input  logic              capture_dr,
  input  logic              shift_dr,
  input  logic              update_dr,
  input  logic              tdi,
  output logic              tdo,
  output logic              bus_req,
  output logic              bus_wr,
  output logic [BUS_AW-1:0] bus_addr,
  output logic [DW-1:0]     bus_wdata,
  input  logic [DW-1:0]     bus_rdata,
  input  logic              bus_ready,
  input  logic              bus_err,
  output logic              bus_abort
);
  logic             rst_s1, rst_n_sync;
  logic [IR_W-1:0]  ir_cur;
  logic [ACC_W-1:0] dr_word;
  logic [ACK_W-1:0] cap_ack;
  logic [DW-1:0]    cap_data;
  logic             ir_tdo, dr_tdo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1     <= 1'b0;
      rst_n_sync <= 1'b0;
    end else begin
      rst_s1     <= 1'b1;
      rst_n_sync <= rst_s1;
    end
  end

  jdp_ir_reg i_ir (
    .clk(clk), .rst_n(rst_n_sync), .tap_reset(tap_reset),
    .capture_ir(capture_ir), .shift_ir(shift_ir), .update_ir(update_ir),
    .tdi(tdi), .ir(ir_cur), .ir_tdo(ir_tdo)
  );

  jdp_dr_shift #(.IDCODE_VALUE(IDCODE_VALUE)) i_dr (
    .clk(clk), .rst_n(rst_n_sync), .ir(ir_cur),
    .capture_dr(capture_dr), .shift_dr(shift_dr), .tdi(tdi),
    .cap_ack(cap_ack), .cap_data(cap_data), .dr(dr_word), .dr_tdo(dr_tdo)
  );

  jdp_core i_core (
    .clk(clk), .rst_n(rst_n_sync), .ir(ir_cur),
    .capture_dr(capture_dr), .update_dr(update_dr), .dr(dr_word),
    .cap_ack(cap_ack), .cap_data(cap_data),
    .bus_req(bus_req), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
    .bus_err(bus_err), .bus_abort(bus_abort)
  );

  assign tdo = shift_ir ? ir_tdo : dr_tdo;
endmodule

// File: rtl/jdp_scan_target_chk.sv
module jdp_scan_target_chk
  import jdp_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              tap_reset,
  input logic [IR_W-1:0]   ir,
  input logic              capture_dr,
  input logic              update_dr,
  input logic [ACK_W-1:0]  cap_ack,
  input logic              bus_req,
  input logic              bus_ready,
  input logic              bus_wr,
  input logic [BUS_AW-1:0] bus_addr,
  input logic [DW-1:0]     bus_wdata,
  input logic              bus_abort
);
  p_ir_default_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tap_reset |=> ir == IR_IDCODE);

  p_ack_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
    capture_dr && bus_req |-> cap_ack == ACK_WAIT);

  p_ack_ok_r4: assert property (@(posedge clk) disable iff (!rst_n)
    capture_dr && !bus_req |-> cap_ack == ACK_OK);

  p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ready && !(update_dr && ir == IR_ABORT)
    |=> bus_req && $stable(bus_addr) && $stable(bus_wr) && $stable(bus_wdata));

  p_req_done_r12: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_ready |=> !bus_req);

  p_abort_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_abort |-> !bus_req);
endmodule

bind jdp_scan_target jdp_scan_target_chk i_chk (
  .clk(clk), .rst_n(rst_n_sync), .tap_reset(tap_reset), .ir(ir_cur),
  .capture_dr(capture_dr), .update_dr(update_dr), .cap_ack(cap_ack),
  .bus_req(bus_req), .bus_ready(bus_ready), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_abort(bus_abort)
);

// File: tb/test_jdp_scan_target.sv
module test_jdp_scan_target;
  import jdp_pkg::*;
  localparam logic [31:0] IDC = 32'h4BA0_1C35;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, tap_reset, capture_ir, shift_ir, update_ir;
  logic        capture_dr, shift_dr, update_dr, tdi, tdo;
  logic        bus_req, bus_wr, bus_ready, bus_err, bus_abort;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [31:0] mem [0:255];

  int checks = 0, errors = 0, lat = 0, wait_cnt = 0, abort_cnt = 0;
  bit err_mode = 0;
  logic [3:0] cur_ir;

  jdp_scan_target #(.IDCODE_VALUE(IDC)) i_jdp_scan_target (
    .clk(clk), .rst_n(rst_n), .tap_reset(tap_reset),
    .capture_ir(capture_ir), .shift_ir(shift_ir), .update_ir(update_ir),
    .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
    .tdi(tdi), .tdo(tdo), .bus_req(bus_req), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ready(bus_ready), .bus_err(bus_err), .bus_abort(bus_abort)
  );

  assign bus_rdata = mem[bus_addr];

  // bus responder with variable latency
  always @(negedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] = '0;
      bus_ready = 0; bus_err = 0; wait_cnt = 0;
    end else if (!bus_req || bus_ready) begin
      bus_ready = 0; bus_err = 0; wait_cnt = 0;
    end else if (wait_cnt >= lat) begin
      bus_ready = 1; bus_err = err_mode;
      if (bus_wr) mem[bus_addr] = bus_wdata;
    end else begin
      wait_cnt++;
    end
    if (bus_abort) abort_cnt++;
  end

  function automatic logic [31:0] pat(int b, int a);
    return 32'(32'hC300_0000 + b * 256 + a * 16 + (b ^ a));
  endfunction

  task automatic chk(input string tag, input logic [34:0] act, input logic [34:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic ir_scan(input logic [3:0] code, output logic [3:0] got);
    got = '0;
    @(negedge clk); capture_ir = 1;
    @(negedge clk); capture_ir = 0; shift_ir = 1;
    for (int i = 0; i < 4; i++) begin
      tdi = code[i]; #1 got[i] = tdo;
      @(negedge clk);
    end
    shift_ir = 0; update_ir = 1;
    @(negedge clk); update_ir = 0;
  endtask

  task automatic dr_scan(input int len, input logic [34:0] din, output logic [34:0] dout);
    dout = '0;
    @(negedge clk); capture_dr = 1;
    @(negedge clk); capture_dr = 0; shift_dr = 1;
    for (int i = 0; i < len; i++) begin
      tdi = din[i]; #1 dout[i] = tdo;
      @(negedge clk);
    end
    shift_dr = 0; update_dr = 1;
    @(negedge clk); update_dr = 0;
  endtask

  task automatic set_ir(input logic [3:0] code);
    logic [3:0] g;
    if (cur_ir !== code) begin
      ir_scan(code, g);
      chk("R2 IR capture pattern", g, 4'b0001);
      cur_ir = code;
    end
  endtask

  task automatic acc(input logic rnw, input logic [1:0] a, input logic [31:0] d,
                     output logic [2:0] ack, output logic [31:0] q);
    logic [34:0] o;
    dr_scan(35, {d, a, rnw}, o);
    ack = o[2:0];
    q   = o[34:3];
  endtask

  task automatic dp_wr(input logic [1:0] a, input logic [31:0] d);
    logic [2:0] k; logic [31:0] q;
    set_ir(IR_DPACC);
    acc(1'b0, a, d, k, q);
    chk("R4 debug-port write ack", k, ACK_OK);
  endtask

  task automatic dp_rd(input logic [1:0] a, output logic [31:0] q);
    logic [2:0] k; logic [31:0] q0;
    set_ir(IR_DPACC);
    acc(1'b1, a, 0, k, q0);
    chk("R4 debug-port read ack", k, ACK_OK);
    acc(1'b1, DPR_RDBUF, 0, k, q);
    chk("R5 read buffer ack", k, ACK_OK);
  endtask

  initial begin
    logic [34:0] o; logic [3:0] g; logic [2:0] k; logic [31:0] q;
    rst_n = 0; tap_reset = 0; capture_ir = 0; shift_ir = 0; update_ir = 0;
    capture_dr = 0; shift_dr = 0; update_dr = 0; tdi = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    cur_ir = IR_IDCODE;

    // R1: reset selects identification
    dr_scan(32, '0, o);
    chk("R1 idcode after reset", o[31:0], IDC);
    chk("R1 idcode bit0", o[0], 1'b1);
    chk("R12 no request after reset", bus_req, 1'b0);

    // R2: every unlisted code acts as bypass
    for (int c = 0; c < 16; c++) begin
      if (c != 8 && c != 10 && c != 11 && c != 14) begin
        set_ir(4'(c));
        dr_scan(2, 35'b01, o);
        chk("R2 bypass length and capture", o[1:0], 2'b10);
      end
    end

    // R3 R8: control/status power bits and select field
    dp_wr(DPR_CTRL, 32'h5000_0001);
    dp_rd(DPR_CTRL, q);
    chk("R8 power acknowledges follow requests", q, 32'hF000_0001);
    dp_wr(DPR_SELECT, 32'hFFFF_FFA5);
    dp_rd(DPR_SELECT, q);
    chk("R9 select keeps bank field only", q, 32'h0000_00A0);
    dp_rd(2'd0, q);
    chk("R3 unused debug-port address reads zero", q, 0);

    // R9: write every bank/register pair
    lat = 3;
    for (int b = 0; b < 16; b++) begin
      dp_wr(DPR_SELECT, 32'(b << 4));
      set_ir(IR_APACC);
      for (int a = 0; a < 4; a++) begin
        acc(1'b0, 2'(a), pat(b, a), k, q);
        chk("R4 access-port write ack", k, ACK_OK);
        repeat (8) @(negedge clk);
      end
    end
    for (int b = 0; b < 16; b++)
      for (int a = 0; a < 4; a++)
        chk("R9 bus address from bank and A[3:2]", mem[b * 16 + a * 4], pat(b, a));

    // R5: pipelined reads return the previous result
    lat = 0;
    for (int b = 0; b < 16; b++) begin
      dp_wr(DPR_SELECT, 32'(b << 4));
      set_ir(IR_APACC);
      acc(1'b1, 2'd0, 0, k, q);
      for (int a = 1; a < 4; a++) begin
        acc(1'b1, 2'(a), 0, k, q);
        chk("R5 posted read data", q, pat(b, a - 1));
      end
      set_ir(IR_DPACC);
      acc(1'b1, DPR_RDBUF, 0, k, q);
      chk("R5 read buffer last posted", q, pat(b, 3));
      acc(1'b1, DPR_RDBUF, 0, k, q);
      chk("R5 read buffer has no side effect", q, pat(b, 3));
    end

    // R6: WAIT with overrun detection on
    lat = 300;
    dp_wr(DPR_SELECT, 0);
    set_ir(IR_APACC);
    acc(1'b0, 2'd0, 32'h1111_0000, k, q);
    chk("R4 idle ack", k, ACK_OK);
    acc(1'b0, 2'd1, 32'h2222_0000, k, q);
    chk("R4 busy ack is WAIT", k, ACK_WAIT);
    repeat (400) @(negedge clk);
    chk("R12 held request completes", mem[0], 32'h1111_0000);
    chk("R6 WAIT write discarded", mem[4], pat(0, 1));
    dp_rd(DPR_CTRL, q);
    chk("R6 sticky overrun set", q, 32'hF000_0003);
    set_ir(IR_APACC);
    acc(1'b0, 2'd2, 32'h3333_0000, k, q);
    chk("R4 ack with sticky set", k, ACK_OK);
    #1 chk("R10 no request while sticky", bus_req, 1'b0);
    repeat (20) @(negedge clk);
    chk("R10 access dropped while sticky", mem[8], pat(0, 2));
    dp_wr(DPR_CTRL, 32'h5000_0003);
    dp_rd(DPR_CTRL, q);
    chk("R7 overrun cleared by writing 1", q, 32'hF000_0001);

    // R6: WAIT with overrun detection off
    dp_wr(DPR_CTRL, 32'h5000_0000);
    set_ir(IR_APACC);
    acc(1'b0, 2'd0, 32'h4444_0000, k, q);
    acc(1'b0, 2'd1, 32'h5555_0000, k, q);
    chk("R4 busy ack is WAIT", k, ACK_WAIT);
    repeat (400) @(negedge clk);
    chk("R6 WAIT write discarded", mem[4], pat(0, 1));
    dp_rd(DPR_CTRL, q);
    chk("R6 no overrun when detection off", q, 32'hF000_0000);

    // R10 R7: bus error
    lat = 1; err_mode = 1;
    set_ir(IR_APACC);
    acc(1'b0, 2'd3, 32'h6666_0000, k, q);
    repeat (10) @(negedge clk);
    err_mode = 0;
    dp_rd(DPR_CTRL, q);
    chk("R10 sticky error set", q, 32'hF000_0020);
    set_ir(IR_APACC);
    acc(1'b0, 2'd3, 32'h7777_0000, k, q);
    repeat (10) @(negedge clk);
    chk("R10 access dropped while error", mem[12], 32'h6666_0000);
    dp_wr(DPR_CTRL, 32'h5000_0000);
    dp_rd(DPR_CTRL, q);
    chk("R7 writing 0 keeps sticky error", q, 32'hF000_0020);
    dp_wr(DPR_CTRL, 32'h5000_0020);
    dp_rd(DPR_CTRL, q);
    chk("R7 sticky error cleared by writing 1", q, 32'hF000_0000);

    // R11: abort
    lat = 1000;
    set_ir(IR_APACC);
    acc(1'b0, 2'd2, 32'h8888_0000, k, q);
    set_ir(IR_ABORT);
    acc(1'b0, 2'd0, 32'h2, k, q);
    #1 chk("R11 abort data 2 ignored", bus_req, 1'b1);
    chk("R11 no abort pulse", abort_cnt, 0);
    acc(1'b0, 2'd0, 32'h1, k, q);
    repeat (2) @(negedge clk);
    chk("R11 abort cancels request", bus_req, 1'b0);
    chk("R11 single abort pulse", abort_cnt, 1);
    chk("R11 aborted write not performed", mem[8], pat(0, 2));
    lat = 0;
    set_ir(IR_APACC);
    acc(1'b0, 2'd2, 32'h9999_0000, k, q);
    chk("R11 port idle after abort", k, ACK_OK);
    repeat (5) @(negedge clk);
    chk("R11 new write after abort", mem[8], 32'h9999_0000);

    // R1: tap reset returns to identification
    set_ir(IR_DPACC);
    @(negedge clk); tap_reset = 1;
    @(negedge clk); tap_reset = 0;
    cur_ir = IR_IDCODE;
    dr_scan(32, '0, o);
    chk("R1 idcode after tap reset", o[31:0], IDC);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule